// File: doc/BRIEF.md
# NOR Flash Program Status Engine

This block is a behavioural front end for a word-organised NOR flash array with a 16-bit data path. Software drives it with single-cycle bus accesses addressed by word. Writes are interpreted as unlock-guarded command sequences that program one word or erase one sector. Reads return either array contents or, while the array is busy, a status word. Completion can be detected in three independent ways: the inverted-data poll bit, the toggling status bit, and an open-drain busy line.

Operation durations are cycle counts. Each count is derived from a time parameter divided by the clock period. A sector erase can be suspended, which frees the array for reads, and later resumed. A separate device reset input aborts any operation, floats the read data and returns the block to read mode.

The storage is a small register array. Erased cells read as all ones, and programming can only clear bits.

Top module: `nor_flash_status_engine`

## Requirements
- R1: After `rst_n` is released the block is in read mode, every word reads 0xFFFF, `busy_pull_low` is 0 and `rdata_oe` is 0.
- R2: A read accepted at a clock edge (`cs`=1, `we`=0, `dev_rst_n`=1) sets `rdata_oe` and `rdata` after that edge. In a cycle with no read, `rdata_oe` is 0 after the edge.
- R3: A word program starts only after this sequence of writes, with commands compared on `wdata[7:0]`: (0x55, 0xAA), (0x2A, 0x55), (0x55, 0xA0), then (target, data). Any write that breaks the sequence returns the block to read mode and leaves the array unchanged.
- R4: A completed program stores the old word ANDed with the new data.
- R5: While busy, a read of any address returns a status word. Its bit 7 is the complement of bit 7 of the data being programmed, or 0 during an erase. Bits 15:8 and 5:0 are 0. This still holds for a read in the same cycle in which the operation completes.
- R6: Status bit 6 is 0 on the first status read of an operation and inverts on every further status read. In read mode, repeated reads return the unchanged array word.
- R7: `busy_pull_low` is 1 for exactly PROG_TIME_NS/CLK_PERIOD_NS cycles after a program starts. For an erase it is 1 for exactly ERASE_TIME_NS/CLK_PERIOD_NS cycles, not counting suspended cycles.
- R8: A sector erase follows this sequence: (0x55, 0xAA), (0x2A, 0x55), (0x55, 0x80), (0x55, 0xAA), (0x2A, 0x55), (any address in the sector, 0x30). Sectors are 16 words (address bits 6:4). On completion every word of that sector reads 0xFFFF and all other words are unchanged.
- R9: During an erase, a write with 0xB0 suspends it. Busy is released, the remaining count is frozen and reads return array data. A write with 0x30 resumes it. A suspend landing on the completion cycle is overridden by completion.
- R10: Writes during a program, including 0xB0, are ignored. The program completes on time with its original data.
- R11: `dev_rst_n` sampled low aborts any operation and leaves the array unchanged. `busy_pull_low` and `rdata_oe` are 0 from the next cycle on, bus accesses are ignored, and the block is in read mode when `dev_rst_n` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous power-up reset, active low; array set to erased |
| dev_rst_n | input | 1 | Device reset, active low; aborts operation and floats data |
| cs | input | 1 | Bus access strobe, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data; commands in bits 7:0 |
| rdata | output | 16 | Read data or status word |
| rdata_oe | output | 1 | Data output enable; 0 means high impedance |
| busy_pull_low | output | 1 | Open-drain busy: 1 = pin pulled low |

## Verification
Two collisions are targeted. The first is a status read landing on the very edge at which the operation counter expires. The bench times a read to that edge and expects the status word, not the new data, followed by array data on the next read. The second is an erase-suspend write arriving on the erase's final cycle. The bench expects completion to win: busy drops, the sector reads erased, and the total busy time is unchanged. A behavioural reference model, compared on every clock, judges all other cycles.

// File: rtl/flash_pkg.sv
package flash_pkg;

    localparam int WORD_W = 16;
    localparam int CMD_W  = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CMD_W-1:0]  cmd_t;

    localparam cmd_t KEY_FIRST  = 8'hAA;
    localparam cmd_t KEY_SECOND = 8'h55;
    localparam cmd_t OP_PROGRAM = 8'hA0;
    localparam cmd_t OP_ERASE   = 8'h80;
    localparam cmd_t OP_SECTOR  = 8'h30;
    localparam cmd_t OP_SUSPEND = 8'hB0;
    localparam cmd_t OP_RESUME  = 8'h30;

    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PARM,
        ST_EARM,
        ST_EUNL1,
        ST_EUNL2,
        ST_PROG,
        ST_ERASE,
        ST_SUSP
    } fl_state_e;

    typedef struct packed {
        logic  oe;
        word_t data;
    } rd_port_t;

endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int PROG_CYC  = 2000,
    parameter int ERASE_CYC = 20000000,
    parameter int CNT_W     = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             start_prog,
    input  logic             start_erase,
    input  logic             hold,
    output logic             running,
    output logic             done,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = tmr_q.run && !hold && (tmr_q.cnt == '0);
        if (abort) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end else if (start_prog) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = CNT_W'(PROG_CYC - 1);
        end else if (start_erase) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = CNT_W'(ERASE_CYC - 1);
        end else if (tmr_q.run && !hold) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign running = tmr_q.run;
    assign count   = tmr_q.cnt;

endmodule

// File: rtl/flash_array.sv
module flash_array
    import flash_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int SECT_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    output word_t                    rd_word,
    input  logic                     prog_en,
    input  logic [ADDR_W-1:0]        prog_addr,
    input  word_t                    prog_data,
    input  logic                     erase_en,
    input  logic [ADDR_W-SECT_W-1:0] erase_sect
);

    localparam int DEPTH = 1 << ADDR_W;

    word_t mem_q [DEPTH];
    word_t mem_d [DEPTH];

    always_comb begin
        logic [ADDR_W-1:0] wa;
        for (int i = 0; i < DEPTH; i++) begin
            wa       = ADDR_W'(i);
            mem_d[i] = mem_q[i];
            if (prog_en && (wa == prog_addr)) begin
                mem_d[i] = mem_q[i] & prog_data;
            end
            if (erase_en && (wa[ADDR_W-1:SECT_W] == erase_sect)) begin
                mem_d[i] = '1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '1;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_word = mem_q[rd_addr];

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int SECT_W = 4,
    parameter int UNL_A1 = 'h55,
    parameter int UNL_A2 = 'h2A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dev_rst_n,
    input  logic                     cs,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  word_t                    wdata,
    input  logic                     tmr_done,
    output logic                     start_prog,
    output logic                     start_erase,
    output logic                     hold,
    output logic                     abort,
    output logic                     prog_en,
    output logic [ADDR_W-1:0]        prog_addr,
    output word_t                    prog_data,
    output logic                     erase_en,
    output logic [ADDR_W-SECT_W-1:0] erase_sect,
    output word_t                    status_word,
    output logic                     busy
);

    localparam int SN_W = ADDR_W - SECT_W;
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(UNL_A1);
    localparam logic [ADDR_W-1:0] A2 = ADDR_W'(UNL_A2);

    typedef struct packed {
        fl_state_e         st;
        logic [ADDR_W-1:0] op_addr;
        word_t             op_data;
        logic [SN_W-1:0]   sect;
        logic              tog;
    } seq_t;

    seq_t seq_d, seq_q;

    logic wr, rd;
    cmd_t cmd;

    assign wr  = cs && we;
    assign rd  = cs && !we;
    assign cmd = wdata[CMD_W-1:0];

    always_comb begin
        seq_d       = seq_q;
        start_prog  = 1'b0;
        start_erase = 1'b0;
        prog_en     = 1'b0;
        erase_en    = 1'b0;
        abort       = !dev_rst_n;
        hold        = (seq_q.st == ST_SUSP);
        busy        = (seq_q.st == ST_PROG) || (seq_q.st == ST_ERASE);

        status_word             = '0;
        status_word[POLL_BIT]   = ~seq_q.op_data[POLL_BIT];
        status_word[TOGGLE_BIT] = seq_q.tog;

        if (!dev_rst_n) begin
            seq_d.st  = ST_READ;
            seq_d.tog = 1'b0;
        end else begin
            if (rd && busy) begin
                seq_d.tog = ~seq_q.tog;
            end
            unique case (seq_q.st)
                ST_READ: begin
                    if (wr && addr == A1 && cmd == KEY_FIRST) begin
                        seq_d.st = ST_UNL1;
                    end
                end
                ST_UNL1: begin
                    if (wr) begin
                        seq_d.st = (addr == A2 && cmd == KEY_SECOND) ? ST_UNL2 : ST_READ;
                    end
                end
                ST_UNL2: begin
                    if (wr) begin
                        if (addr == A1 && cmd == OP_PROGRAM) begin
                            seq_d.st = ST_PARM;
                        end else if (addr == A1 && cmd == OP_ERASE) begin
                            seq_d.st = ST_EARM;
                        end else begin
                            seq_d.st = ST_READ;
                        end
                    end
                end
                ST_PARM: begin
                    if (wr) begin
                        seq_d.st      = ST_PROG;
                        seq_d.op_addr = addr;
                        seq_d.op_data = wdata;
                        seq_d.tog     = 1'b0;
                        start_prog    = 1'b1;
                    end
                end
                ST_EARM: begin
                    if (wr) begin
                        seq_d.st = (addr == A1 && cmd == KEY_FIRST) ? ST_EUNL1 : ST_READ;
                    end
                end
                ST_EUNL1: begin
                    if (wr) begin
                        seq_d.st = (addr == A2 && cmd == KEY_SECOND) ? ST_EUNL2 : ST_READ;
                    end
                end
                ST_EUNL2: begin
                    if (wr) begin
                        if (cmd == OP_SECTOR) begin
                            seq_d.st      = ST_ERASE;
                            seq_d.sect    = addr[ADDR_W-1:SECT_W];
                            seq_d.op_data = '1;
                            seq_d.tog     = 1'b0;
                            start_erase   = 1'b1;
                        end else begin
                            seq_d.st = ST_READ;
                        end
                    end
                end
                ST_PROG: begin
                    if (tmr_done) begin
                        prog_en  = 1'b1;
                        seq_d.st = ST_READ;
                    end
                end
                ST_ERASE: begin
                    if (tmr_done) begin
                        erase_en = 1'b1;
                        seq_d.st = ST_READ;
                    end else if (wr && cmd == OP_SUSPEND) begin
                        seq_d.st = ST_SUSP;
                    end
                end
                ST_SUSP: begin
                    if (wr && cmd == OP_RESUME) begin
                        seq_d.st = ST_ERASE;
                    end
                end
                default: seq_d.st = ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_READ;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign prog_addr  = seq_q.op_addr;
    assign prog_data  = seq_q.op_data;
    assign erase_sect = seq_q.sect;

endmodule

// File: rtl/nor_flash_status_engine.sv
module nor_flash_status_engine
    import flash_pkg::*;
#(
    parameter int ADDR_W        = 7,
    parameter int SECT_W        = 4,
    parameter int CLK_PERIOD_NS = 10,
    parameter int PROG_TIME_NS  = 20000,
    parameter int ERASE_TIME_NS = 200000000,
    parameter int UNL_A1        = 'h55,
    parameter int UNL_A2        = 'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              rdata_oe,
    output logic              busy_pull_low
);

    localparam int PROG_RAW  = PROG_TIME_NS / CLK_PERIOD_NS;
    localparam int ERASE_RAW = ERASE_TIME_NS / CLK_PERIOD_NS;
    localparam int PROG_CYC  = (PROG_RAW < 1) ? 1 : PROG_RAW;
    localparam int ERASE_CYC = (ERASE_RAW < 1) ? 1 : ERASE_RAW;
    localparam int MAX_CYC   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam int SN_W      = ADDR_W - SECT_W;

    logic             tmr_running, tmr_done, tmr_hold, tmr_abort;
    logic             start_prog, start_erase;
    logic [CNT_W-1:0] tmr_count;
    logic             prog_en, erase_en, seq_busy;
    logic [ADDR_W-1:0] prog_addr;
    logic [SN_W-1:0]  erase_sect;
    word_t            prog_data, status_word, arr_word;

    rd_port_t port_d, port_q;

    flash_seq #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W),
        .UNL_A1 (UNL_A1),
        .UNL_A2 (UNL_A2)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_rst_n   (dev_rst_n),
        .cs          (cs),
        .we          (we),
        .addr        (addr),
        .wdata       (wdata),
        .tmr_done    (tmr_done),
        .start_prog  (start_prog),
        .start_erase (start_erase),
        .hold        (tmr_hold),
        .abort       (tmr_abort),
        .prog_en     (prog_en),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .erase_en    (erase_en),
        .erase_sect  (erase_sect),
        .status_word (status_word),
        .busy        (seq_busy)
    );

    flash_op_timer #(
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort       (tmr_abort),
        .start_prog  (start_prog),
        .start_erase (start_erase),
        .hold        (tmr_hold),
        .running     (tmr_running),
        .done        (tmr_done),
        .count       (tmr_count)
    );

    flash_array #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (addr),
        .rd_word    (arr_word),
        .prog_en    (prog_en),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .erase_en   (erase_en),
        .erase_sect (erase_sect)
    );

    always_comb begin
        port_d    = port_q;
        port_d.oe = 1'b0;
        if (dev_rst_n && cs && !we) begin
            port_d.oe   = 1'b1;
            port_d.data = seq_busy ? status_word : arr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign rdata         = port_q.data;
    assign rdata_oe      = port_q.oe;
    assign busy_pull_low = seq_busy;

endmodule

// File: rtl/flash_engine_checker.sv
module flash_engine_checker #(
    parameter int CNT_W = 25
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dev_rst_n,
    input logic             cs,
    input logic             we,
    input logic [15:0]      rdata,
    input logic             rdata_oe,
    input logic             busy_pull_low,
    input logic             tmr_running,
    input logic             tmr_hold,
    input logic [CNT_W-1:0] tmr_count
);

    // R11: device reset releases busy and floats data on the next cycle
    a_r11_reset_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rst_n |=> (!busy_pull_low && !rdata_oe));

    // R2: an accepted read drives the data bus next cycle
    a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rst_n && cs && !we) |=> rdata_oe);

    // R2: no read means the data bus floats next cycle
    a_r2_idle_floats: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && !we) |=> !rdata_oe);

    // R5: status words carry only the poll and toggle bits
    a_r5_status_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && $past(busy_pull_low)) |-> (rdata[15:8] == 8'h00 && rdata[5:0] == 6'h00));

    // R7: the busy pin is never low without a running operation counter
    a_r7_busy_has_timer: assert property (@(posedge clk) disable iff (!rst_n)
        busy_pull_low |-> tmr_running);

    // R9: a suspended erase keeps its remaining count
    a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_running && tmr_hold && dev_rst_n) |=> $stable(tmr_count));

endmodule

bind nor_flash_status_engine flash_engine_checker #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dev_rst_n     (dev_rst_n),
    .cs            (cs),
    .we            (we),
    .rdata         (rdata),
    .rdata_oe      (rdata_oe),
    .busy_pull_low (busy_pull_low),
    .tmr_running   (tmr_running),
    .tmr_hold      (tmr_hold),
    .tmr_count     (tmr_count)
);

// File: tb/nor_flash_status_engine_tb.sv
module nor_flash_status_engine_tb;

    localparam int AW  = 7;
    localparam int PC  = 30;
    localparam int EC  = 120;

    localparam int S_RD = 0, S_U1 = 1, S_U2 = 2, S_PA = 3, S_EA = 4,
                   S_E1 = 5, S_E2 = 6, S_PG = 7, S_ER = 8, S_SU = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dev_rst_n = 1'b1;
    logic          cs = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          rdata_oe;
    logic          busy_pull_low;

    always #5 clk = ~clk;

    nor_flash_status_engine #(
        .ADDR_W        (AW),
        .SECT_W        (4),
        .CLK_PERIOD_NS (10),
        .PROG_TIME_NS  (300),
        .ERASE_TIME_NS (1200),
        .UNL_A1        ('h55),
        .UNL_A2        ('h2A)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .dev_rst_n     (dev_rst_n),
        .cs            (cs),
        .we            (we),
        .addr          (addr),
        .wdata         (wdata),
        .rdata         (rdata),
        .rdata_oe      (rdata_oe),
        .busy_pull_low (busy_pull_low)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int busy_seen = 0;
    bit fin = 1'b0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [15:0] m_mem [128];
    int          m_st = 0;
    int          m_left = 0;
    logic        m_tog = 1'b0;
    logic        m_oe = 1'b0;
    logic [15:0] m_rd = '0;
    logic [15:0] m_opd = '0;
    logic [6:0]  m_opa = '0;
    int          m_sect = 0;

    always @(posedge clk) begin : model
        bit busy_now;
        bit fin_edge;
        logic [7:0] c;
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) m_mem[i] = 16'hFFFF;
            m_st = S_RD; m_left = 0; m_tog = 1'b0; m_oe = 1'b0; m_rd = '0; m_opd = '0;
        end else if (!dev_rst_n) begin
            m_st = S_RD; m_left = 0; m_tog = 1'b0; m_oe = 1'b0;
        end else begin
            busy_now = (m_st == S_PG) || (m_st == S_ER);
            c = wdata[7:0];
            if (cs && !we) begin
                m_oe = 1'b1;
                if (busy_now) begin
                    m_rd = {8'h00, ~m_opd[7], m_tog, 6'b000000};
                    m_tog = ~m_tog;
                end else begin
                    m_rd = m_mem[addr];
                end
            end else begin
                m_oe = 1'b0;
            end
            fin_edge = 1'b0;
            if (busy_now) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    fin_edge = 1'b1;
                    if (m_st == S_PG) m_mem[m_opa] = m_mem[m_opa] & m_opd;
                    else for (int i = 0; i < 128; i++) if ((i >> 4) == m_sect) m_mem[i] = 16'hFFFF;
                    m_st = S_RD;
                end
            end
            if (cs && we && !fin_edge) begin
                case (m_st)
                    S_RD: if (addr == 7'h55 && c == 8'hAA) m_st = S_U1;
                    S_U1: m_st = (addr == 7'h2A && c == 8'h55) ? S_U2 : S_RD;
                    S_U2: m_st = (addr == 7'h55 && c == 8'hA0) ? S_PA :
                                 (addr == 7'h55 && c == 8'h80) ? S_EA : S_RD;
                    S_PA: begin m_st = S_PG; m_opa = addr; m_opd = wdata; m_left = PC; m_tog = 1'b0; end
                    S_EA: m_st = (addr == 7'h55 && c == 8'hAA) ? S_E1 : S_RD;
                    S_E1: m_st = (addr == 7'h2A && c == 8'h55) ? S_E2 : S_RD;
                    S_E2: if (c == 8'h30) begin
                              m_st = S_ER; m_sect = int'(addr >> 4); m_opd = 16'hFFFF;
                              m_left = EC; m_tog = 1'b0;
                          end else m_st = S_RD;
                    S_ER: if (c == 8'hB0) m_st = S_SU;
                    S_SU: if (c == 8'h30) m_st = S_ER;
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk("R2 model rdata_oe", {15'd0, rdata_oe}, {15'd0, m_oe});
            chk("R7 model busy", {15'd0, busy_pull_low},
                {15'd0, ((m_st == S_PG) || (m_st == S_ER)) ? 1'b1 : 1'b0});
            if (m_oe) chk("R5 model rdata", rdata, m_rd);
            if (busy_pull_low) busy_seen++;
        end
    end

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] v);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a;
        @(posedge clk);
        #2 v = rdata;
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic unlock();
        wr(7'h55, 16'h00AA);
        wr(7'h2A, 16'h0055);
    endtask

    task automatic prog(input logic [6:0] a, input logic [15:0] d);
        unlock();
        wr(7'h55, 16'h00A0);
        busy_seen = 0;
        wr(a, d);
    endtask

    task automatic erase(input logic [6:0] a);
        unlock();
        wr(7'h55, 16'h0080);
        unlock();
        busy_seen = 0;
        wr(a, 16'h0030);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy_pull_low && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin : main
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", {15'd0, busy_pull_low}, 16'h0000);
        chk("R1 oe after reset", {15'd0, rdata_oe}, 16'h0000);
        rd(7'h00, v); chk("R1 erased word 0x00", v, 16'hFFFF);
        rd(7'h7F, v); chk("R1 erased word 0x7F", v, 16'hFFFF);
        chk("R2 oe during read sample", {15'd0, rdata_oe}, 16'h0001);

        // basic program and timing
        prog(7'h10, 16'h12C3);
        wait_idle();
        chk("R7 program busy cycles", 16'(busy_seen), 16'(PC));
        rd(7'h10, v); chk("R3 programmed word", v, 16'h12C3);

        // AND semantics plus poll and toggle
        prog(7'h10, 16'hFF0F);
        rd(7'h10, v); chk("R5 R6 first status", v, 16'h0080);
        rd(7'h00, v); chk("R6 second status toggles", v, 16'h00C0);
        rd(7'h10, v); chk("R6 third status toggles back", v, 16'h0080);
        wait_idle();
        rd(7'h10, v); chk("R4 old AND new", v, 16'h1203);
        rd(7'h10, v); chk("R6 read mode no toggle", v, 16'h1203);

        // broken sequence
        wr(7'h55, 16'h00AA);
        wr(7'h2A, 16'h0011);
        wr(7'h55, 16'h00A0);
        wr(7'h20, 16'h0000);
        chk("R3 broken sequence not busy", {15'd0, busy_pull_low}, 16'h0000);
        rd(7'h20, v); chk("R3 broken sequence no write", v, 16'hFFFF);

        // writes ignored during program
        prog(7'h21, 16'h00F0);
        wr(7'h21, 16'h0000);
        wr(7'h00, 16'h00B0);
        chk("R10 still busy after writes", {15'd0, busy_pull_low}, 16'h0001);
        wait_idle();
        chk("R10 program time unchanged", 16'(busy_seen), 16'(PC));
        rd(7'h21, v); chk("R10 original data kept", v, 16'h00F0);

        // erase with suspend
        prog(7'h30, 16'hABCD);
        wait_idle();
        erase(7'h18);
        rd(7'h10, v); chk("R5 erase status bit7 zero", v, 16'h0000);
        rd(7'h10, v); chk("R6 erase status toggles", v, 16'h0040);
        wr(7'h00, 16'h00B0);
        chk("R9 suspend releases busy", {15'd0, busy_pull_low}, 16'h0000);
        rd(7'h10, v); chk("R9 suspended sector readable", v, 16'h1203);
        rd(7'h30, v); chk("R9 other sector readable", v, 16'hABCD);
        repeat (10) @(negedge clk);
        chk("R9 stays suspended", {15'd0, busy_pull_low}, 16'h0000);
        wr(7'h00, 16'h0030);
        chk("R9 resume sets busy", {15'd0, busy_pull_low}, 16'h0001);
        wait_idle();
        chk("R9 erase time excludes suspend", 16'(busy_seen), 16'(EC));
        rd(7'h10, v); chk("R8 sector word erased", v, 16'hFFFF);
        rd(7'h1F, v); chk("R8 sector end erased", v, 16'hFFFF);
        rd(7'h21, v); chk("R8 neighbour untouched", v, 16'h00F0);
        rd(7'h30, v); chk("R8 far sector untouched", v, 16'hABCD);

        // device reset during program
        prog(7'h40, 16'h0000);
        repeat (5) @(negedge clk);
        dev_rst_n = 1'b0;
        @(negedge clk);
        chk("R11 busy released", {15'd0, busy_pull_low}, 16'h0000);
        rd(7'h40, v);
        chk("R11 data floats", {15'd0, rdata_oe}, 16'h0000);
        dev_rst_n = 1'b1;
        rd(7'h40, v); chk("R11 aborted word unchanged", v, 16'hFFFF);
        prog(7'h40, 16'h5A5A);
        wait_idle();
        rd(7'h40, v); chk("R11 read mode after release", v, 16'h5A5A);

        // device reset during erase
        erase(7'h35);
        repeat (4) @(negedge clk);
        dev_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        dev_rst_n = 1'b1;
        chk("R11 erase aborted", {15'd0, busy_pull_low}, 16'h0000);
        rd(7'h30, v); chk("R11 erase left sector intact", v, 16'hABCD);

        // status read on the completion edge
        prog(7'h50, 16'h0055);
        repeat (PC - 2) @(negedge clk);
        rd(7'h50, v); chk("R5 status on completion edge", v, 16'h0080);
        chk("R7 idle after completion", {15'd0, busy_pull_low}, 16'h0000);
        rd(7'h50, v); chk("R4 data after completion", v, 16'h0055);

        // suspend on the completion edge
        erase(7'h44);
        repeat (EC - 2) @(negedge clk);
        wr(7'h00, 16'h00B0);
        chk("R9 completion beats suspend", {15'd0, busy_pull_low}, 16'h0000);
        chk("R9 full erase time", 16'(busy_seen), 16'(EC));
        rd(7'h40, v); chk("R8 sector erased after late suspend", v, 16'hFFFF);

        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!fin) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule